// File: doc/BRIEF.md
# Logic Analyzer Trigger Match Unit

This block is one configurable match circuit for the trigger logic of a multi-channel logic analyzer. It evaluates every incoming sample word against a condition selected at run time. The condition is one of four kinds:

- a per-channel edge condition, combined across channels with OR;
- a ternary pattern, combined across channels with AND;
- a check that the word has not changed since the previous sample;
- an unsigned magnitude comparison against an operand.

A qualifying counter can demand that the condition holds for a programmed number of consecutive samples before a match is reported. The counter saturates, so the match stays asserted while the condition keeps holding.

The result is one registered flag per sample. It is high in the cycle after a valid sample whose condition is met and qualified. In every other cycle it is low. Trigger sequencing, combining several circuits and sample storage sit outside this block.

Top module: `trig_match_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `match_q` is 0.
- R2: `match_q` is high only in the cycle that follows a cycle with `smp_vld` = 1. A cycle with `smp_vld` = 0 yields `match_q` = 0 in the next cycle.
- R3: Mode 0 (edge) matches when at least one channel i sees one of two events. The first event is a 0-to-1 change with `cfg_rise[i]` = 1. The second is a 1-to-0 change with `cfg_fall[i]` = 1. Each change is measured between the previous valid sample and the current one.
- R4: Mode 1 (pattern) matches when `smp_data[i]` equals `cfg_operand[i]` for every channel i with `cfg_care[i]` = 1. Channels with `cfg_care[i]` = 0 are don't-care.
- R5: Mode 2 (stable) matches when the current valid sample equals the previous valid sample on all channels.
- R6: Modes 3, 4, 5, 6 and 7 compare `smp_data` with `cfg_operand` as unsigned numbers. The tests are, in that order of mode, >, >=, <, <= and not-equal.
- R7: A match is reported on a valid sample only if the condition has held on at least `cfg_dur` consecutive valid samples, counting that sample. A sample whose condition is false restarts the count. Cycles without `smp_vld` neither advance nor break the run. A `cfg_dur` of 0 or 1 reports the match at once.
- R8: Edges and stability are never reported on the first valid sample after reset. They are also not reported on the first valid sample after `cfg_mode` changes value. A change of `cfg_mode` also restarts the duration count.
- R9: The run counter saturates at its maximum value. With `cfg_dur` at that maximum, every further true sample in an unbroken run keeps matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Marks `smp_data` as a new sample |
| smp_data | input | CH_W | Sample word, one bit per channel |
| cfg_mode | input | 3 | Condition select: 0 edge, 1 pattern, 2 stable, 3 >, 4 >=, 5 <, 6 <=, 7 not-equal |
| cfg_operand | input | CH_W | Pattern bit values, or the relational operand |
| cfg_care | input | CH_W | Pattern mask; 1 = channel is compared |
| cfg_rise | input | CH_W | Edge mode: channel fires on a rising edge |
| cfg_fall | input | CH_W | Edge mode: channel fires on a falling edge |
| cfg_dur | input | DUR_W | Required run length in samples |
| match_q | output | 1 | Registered match flag |

## Verification
The bench builds the unit with `CH_W` = 4 and `DUR_W` = 4. With these values a 4-channel word makes it practical to sweep every operand and sample pair in each relational mode. It also makes it practical to cover every value, mask and sample combination in pattern mode. Every rise/fall enable pair in edge mode is driven with a long sample stream, and every sample pair is driven in stable mode. A 4-bit run counter lets the bench try every duration limit, including the saturated maximum, within short runs that include idle cycles.

// File: rtl/trig_match_pkg.sv
package trig_match_pkg;
    typedef enum logic [2:0] {
        TM_EDGE    = 3'd0,
        TM_PATTERN = 3'd1,
        TM_STABLE  = 3'd2,
        TM_GT      = 3'd3,
        TM_GE      = 3'd4,
        TM_LT      = 3'd5,
        TM_LE      = 3'd6,
        TM_NE      = 3'd7
    } tm_mode_e;
endpackage

// File: rtl/trig_edge_detect.sv
module trig_edge_detect #(
    parameter int W = 9
) (
    input  logic [W-1:0] prev_word,
    input  logic [W-1:0] cur_word,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic         any_edge
);
    logic [W-1:0] chan_hit;

    for (genvar i = 0; i < W; i++) begin : g_chan
        always_comb begin
            chan_hit[i] = (rise_en[i] && !prev_word[i] &&  cur_word[i]) ||
                          (fall_en[i] &&  prev_word[i] && !cur_word[i]);
        end
    end

    assign any_edge = |chan_hit;
endmodule

// File: rtl/trig_rel_cmp.sv
module trig_rel_cmp
    import trig_match_pkg::*;
#(
    parameter int W = 9
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic [2:0]   mode,
    output logic         rel_true
);
    logic gt, eq;

    always_comb begin
        gt = lhs > rhs;
        eq = lhs == rhs;
        case (tm_mode_e'(mode))
            TM_GT:   rel_true = gt;
            TM_GE:   rel_true = gt || eq;
            TM_LT:   rel_true = !gt && !eq;
            TM_LE:   rel_true = !gt;
            TM_NE:   rel_true = !eq;
            default: rel_true = 1'b0;
        endcase
    end
endmodule

// File: rtl/trig_dur_qual.sv
module trig_dur_qual #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          restart,
    input  logic          cond,
    input  logic [CW-1:0] limit,
    output logic          qualified
);
    localparam logic [CW-1:0] RUN_MAX = '1;

    logic [CW-1:0] run_d, run_q;
    logic [CW-1:0] base, bumped;

    always_comb begin
        base      = restart ? '0 : run_q;
        bumped    = (base == RUN_MAX) ? base : base + 1'b1;
        qualified = step && cond && (bumped >= limit);
        if (step) begin
            run_d = cond ? bumped : '0;
        end else begin
            run_d = base;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
    import trig_match_pkg::*;
#(
    parameter int CH_W  = 9,
    parameter int DUR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [CH_W-1:0]  smp_data,
    input  logic [2:0]       cfg_mode,
    input  logic [CH_W-1:0]  cfg_operand,
    input  logic [CH_W-1:0]  cfg_care,
    input  logic [CH_W-1:0]  cfg_rise,
    input  logic [CH_W-1:0]  cfg_fall,
    input  logic [DUR_W-1:0] cfg_dur,
    output logic             match_q
);
    typedef struct packed {
        logic [CH_W-1:0] prev;
        logic            hist;
        logic [2:0]      mode;
        logic            match;
    } tm_state_t;

    tm_state_t st_d, st_q;

    logic same_mode, hist_ok;
    logic edge_raw, rel_raw, pattern_raw, stable_raw, cond;
    logic qual_hit;

    trig_edge_detect #(.W(CH_W)) u_edge (
        .prev_word (st_q.prev),
        .cur_word  (smp_data),
        .rise_en   (cfg_rise),
        .fall_en   (cfg_fall),
        .any_edge  (edge_raw)
    );

    trig_rel_cmp #(.W(CH_W)) u_rel (
        .lhs      (smp_data),
        .rhs      (cfg_operand),
        .mode     (cfg_mode),
        .rel_true (rel_raw)
    );

    trig_dur_qual #(.CW(DUR_W)) u_dur (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (smp_vld),
        .restart   (!same_mode),
        .cond      (cond),
        .limit     (cfg_dur),
        .qualified (qual_hit)
    );

    always_comb begin
        same_mode   = cfg_mode == st_q.mode;
        hist_ok     = st_q.hist && same_mode;
        pattern_raw = ((smp_data ^ cfg_operand) & cfg_care) == '0;
        stable_raw  = smp_data == st_q.prev;

        case (tm_mode_e'(cfg_mode))
            TM_EDGE:    cond = hist_ok && edge_raw;
            TM_PATTERN: cond = pattern_raw;
            TM_STABLE:  cond = hist_ok && stable_raw;
            default:    cond = rel_raw;
        endcase

        st_d       = st_q;
        st_d.mode  = cfg_mode;
        st_d.match = qual_hit;
        if (smp_vld) begin
            st_d.prev = smp_data;
            st_d.hist = 1'b1;
        end else begin
            st_d.hist = hist_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{prev: '0, hist: 1'b0, mode: TM_EDGE, match: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign match_q = st_q.match;
endmodule

// File: rtl/trig_match_unit_chk.sv
module trig_match_unit_chk #(
    parameter int CH_W  = 9,
    parameter int DUR_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_vld,
    input logic [CH_W-1:0]  smp_data,
    input logic [2:0]       cfg_mode,
    input logic [CH_W-1:0]  cfg_operand,
    input logic [CH_W-1:0]  cfg_care,
    input logic [DUR_W-1:0] cfg_dur,
    input logic             match_q
);
    logic       seen_q;
    logic [2:0] mode_seen_q;
    logic       seen_ok;
    logic       rst_seen_q;

    assign seen_ok = seen_q && (cfg_mode == mode_seen_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            mode_seen_q <= 3'd0;
            rst_seen_q  <= 1'b1;
        end else begin
            seen_q      <= smp_vld || seen_ok;
            mode_seen_q <= cfg_mode;
            rst_seen_q  <= 1'b0;
        end
    end

    // R1: first cycle out of reset shows no match
    always @(negedge clk) begin
        if (rst_n && rst_seen_q) begin
            a_reset_quiet_r1: assert (!match_q);
        end
    end

    p_idle_no_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> !match_q);

    p_pattern_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && cfg_mode == 3'd1 && cfg_dur <= 1 &&
         ((smp_data ^ cfg_operand) & cfg_care) == '0) |=> match_q);

    p_greater_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && cfg_mode == 3'd3 && cfg_dur <= 1 && smp_data > cfg_operand)
        |=> match_q);

    p_ne_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && cfg_mode == 3'd7 && smp_data == cfg_operand) |=> !match_q);

    p_first_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !seen_ok && (cfg_mode == 3'd0 || cfg_mode == 3'd2))
        |=> !match_q);
endmodule

bind trig_match_unit trig_match_unit_chk #(.CH_W(CH_W), .DUR_W(DUR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_vld     (smp_vld),
    .smp_data    (smp_data),
    .cfg_mode    (cfg_mode),
    .cfg_operand (cfg_operand),
    .cfg_care    (cfg_care),
    .cfg_dur     (cfg_dur),
    .match_q     (match_q)
);

// File: tb/trig_match_unit_test.sv
`timescale 1ns/1ps
module trig_match_unit_test;
    localparam int CH_W  = 4;
    localparam int DUR_W = 4;
    localparam int RMAX  = 15;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             smp_vld = 1'b0;
    logic [CH_W-1:0]  smp_data = '0;
    logic [2:0]       cfg_mode = 3'd0;
    logic [CH_W-1:0]  cfg_operand = '0;
    logic [CH_W-1:0]  cfg_care = '0;
    logic [CH_W-1:0]  cfg_rise = '0;
    logic [CH_W-1:0]  cfg_fall = '0;
    logic [DUR_W-1:0] cfg_dur = '0;
    logic             match_q;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // reference model state
    int m_prev = 0;
    bit m_hist = 1'b0;
    int m_mode = 0;
    int m_run  = 0;

    always #2 clk = ~clk;

    trig_match_unit #(.CH_W(CH_W), .DUR_W(DUR_W)) uut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .cfg_mode(cfg_mode), .cfg_operand(cfg_operand), .cfg_care(cfg_care),
        .cfg_rise(cfg_rise), .cfg_fall(cfg_fall), .cfg_dur(cfg_dur),
        .match_q(match_q)
    );

    task automatic check(input bit exp, input string tag);
        vectors++;
        if (match_q !== exp) begin
            errors++;
            $display("FAIL %s: match_q=%0b expected=%0b (mode=%0d data=%0d)",
                     tag, match_q, exp, cfg_mode, smp_data);
        end
    endtask

    function automatic bit raw_cond(input int d);
        int p, o, c;
        p = m_prev; o = int'(cfg_operand); c = int'(cfg_care);
        case (m_mode)
            0: return m_hist && (((~p & d & int'(cfg_rise)) |
                                  (p & ~d & int'(cfg_fall))) & 15) != 0;
            1: return ((d ^ o) & c) == 0;
            2: return m_hist && (d == p);
            3: return d > o;
            4: return d >= o;
            5: return d < o;
            6: return d <= o;
            default: return d != o;
        endcase
    endfunction

    // one valid sample; called right after a falling edge
    task automatic samp(input int d, input string tag);
        bit r, e;
        r = raw_cond(d);
        if (r) m_run = (m_run < RMAX) ? m_run + 1 : RMAX;
        else   m_run = 0;
        e = r && (m_run >= int'(cfg_dur));
        m_prev = d; m_hist = 1'b1;
        smp_vld = 1'b1; smp_data = d[CH_W-1:0];
        @(negedge clk);
        check(e, tag);
    endtask

    task automatic idle(input string tag);
        smp_vld = 1'b0;
        @(negedge clk);
        check(1'b0, tag);
    endtask

    task automatic set_mode(input int m);
        cfg_mode = m[2:0];
        if (m != m_mode) begin
            m_hist = 1'b0;
            m_run  = 0;
        end
        m_mode = m;
        idle("R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1");

        // R8: stable mode, first sample after reset cannot match
        cfg_dur = 4'd1;
        set_mode(2);
        samp(5, "R8");
        samp(5, "R5");
        idle("R2");
        samp(5, "R5");

        // R5: every ordered pair of samples
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                samp(a, "R5");
                samp(b, "R5");
            end
        end

        // R8: switching to edge mode invalidates history
        cfg_rise = 4'hF; cfg_fall = 4'hF;
        set_mode(0);
        samp(10, "R8");
        samp(5, "R3");

        // R3: every rise/fall enable pair over a sample stream
        for (int rf = 0; rf < 256; rf++) begin
            cfg_rise = rf[3:0];
            cfg_fall = rf[7:4];
            for (int k = 0; k < 32; k++) begin
                samp((k * 5 + (k >> 2) * 3 + rf) % 16, "R3");
            end
        end

        // R4: every value, mask and sample
        set_mode(1);
        for (int v = 0; v < 16; v++) begin
            for (int c = 0; c < 16; c++) begin
                cfg_operand = v[3:0];
                cfg_care    = c[3:0];
                for (int d = 0; d < 16; d++) samp(d, "R4");
            end
        end

        // R6: each relational mode, every operand and sample
        for (int m = 3; m < 8; m++) begin
            set_mode(m);
            for (int o = 0; o < 16; o++) begin
                cfg_operand = o[3:0];
                for (int d = 0; d < 16; d++) samp(d, "R6");
            end
        end

        // R7 / R9: every duration limit with breaks and idle gaps
        set_mode(3);
        cfg_operand = 4'd7;
        for (int du = 0; du < 16; du++) begin
            cfg_dur = du[3:0];
            samp(2, "R7");
            for (int i = 0; i < 48; i++) begin
                if (i % 5 == 0) idle("R7");
                samp((i % 23 == 22) ? 2 : 9, (du == RMAX) ? "R9" : "R7");
            end
        end

        // R8: mode change restarts the duration count
        cfg_dur = 4'd3;
        samp(9, "R7");
        samp(9, "R7");
        set_mode(4);
        samp(9, "R8");
        samp(9, "R8");
        samp(9, "R7");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule